// File: doc/BRIEF.md
# SAR Conversion and Serial Readout Sequencer

This block is the digital controller of a single-channel successive-approximation converter. It keeps the sampler tracking while the start strobe idles low, treats a high strobe as the auto-zero phase, and starts a conversion when the strobe falls. The conversion runs on an internal tick divided from the system clock, one trial per tick from the top bit down. The result is then presented MSB first on a serial output that advances on each falling edge of an external serial clock.

The analog comparator, capacitor DAC and reference are outside the block. The block drives a trial code to the DAC and reads back a single comparator bit. The start strobe, serial clock and active-low shutdown are asynchronous to the system clock. They are synchronised and edge-detected inside. The block enforces the restart rules: a new start is taken only once the previous result has been fully read. Rule breaks raise a sticky error flag, and a shutdown that cuts a conversion short forces a recovery sequence before the next start.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, track_o=1, sdo_oe_o=0, valid_o=0, err_o=0 and dac_code_o=0.
- R2: A rising start_i in idle begins auto-zero (track_o stays 1). Its falling edge starts a conversion: track_o=0, sdo_oe_o=1 and sdo_o=0 until the result is ready. A start taken in idle also clears err_o.
- R3: The conversion tests bit N_BITS-1 first and bit 0 last, one bit per internal tick of DIV system clocks. A bit is kept when cmp_i=1, which means the input is at or above the trial code. After the last trial, dac_code_o equals the ideal code: the largest code not above the input.
- R4: When the last trial completes, sdo_o presents the MSB with no serial-clock edge, valid_o=1, and track_o returns to 1.
- R5: Each falling sclk_i edge taken while start_i is low moves sdo_o to the next lower bit (straight binary). After the N_BITS-th falling edge sdo_oe_o=0, and it stays 0 on further edges.
- R6: A rising start_i during readout sets err_o and does not restart. A falling sclk_i while start_i is high does not shift. The readout continues once start_i is low.
- R7: Any sclk_i edge during a conversion sets err_o.
- R8: A rising start_i during a conversion sets err_o. The running conversion still completes with a valid result.
- R9: shdn_ni low stops a conversion and drives sdo_oe_o=0, track_o=0 and valid_o=0 within three system clocks.
- R10: After a shutdown that stopped a conversion, start_i is ignored until N_BITS internal ticks have passed and then N_BITS falling sclk_i edges have been taken. After that, conversions work normally.
- R11: A shutdown taken in idle needs no recovery; a start is accepted as soon as shdn_ni returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe: high = auto-zero, falling edge = convert |
| sclk_i | input | 1 | Serial readout clock, falling edge shifts |
| shdn_ni | input | 1 | Active-low shutdown |
| cmp_i | input | 1 | Comparator: 1 = input at or above trial code |
| dac_code_o | output | N_BITS | Trial code to the DAC, holds the result after conversion |
| sdo_o | output | 1 | Serial data |
| sdo_oe_o | output | 1 | Output enable for sdo_o (0 = high impedance) |
| track_o | output | 1 | 1 = sampler tracking, 0 = holding or powered down |
| valid_o | output | 1 | Result of the last conversion is available |
| err_o | output | 1 | Sticky rule-violation flag |

## Verification
The assertions assume that start_i, sclk_i and shdn_ni each stay at a level for more than three system clocks, so that every edge passes the synchroniser and is seen once. They also assume cmp_i responds to dac_code_o within the same cycle. The bench holds every strobe and clock phase for at least four system clocks and models the comparator as a combinational compare of an ideal input code against the trial code. The bench sweeps all 256 input codes through a full conversion and readout, then breaks each rule on purpose to exercise the error and shutdown paths.

// File: rtl/adc_conv_seq_pkg.sv
package adc_conv_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_AZ, ST_CONV, ST_READ, ST_OFF, ST_RWAIT, ST_RCLR
  } seq_st_e;
endpackage

// File: rtl/adc_conv_seq_sync.sv
module adc_conv_seq_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/adc_conv_seq_div.sv
module adc_conv_seq_div #(
  parameter int DIV = 625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
  assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/adc_conv_seq_sar.sv
module adc_conv_seq_sar #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         abort_i,
  input  logic         tick_i,
  input  logic         cmp_i,
  output logic [N-1:0] dac_o,
  output logic [N-1:0] res_o,
  output logic         done_o
);
  logic [N-1:0] code_q, mask_q;
  assign res_o  = code_q | (cmp_i ? mask_q : '0);
  assign dac_o  = code_q | mask_q;
  assign done_o = tick_i && mask_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      mask_q <= '0;
    end else if (abort_i) begin
      mask_q <= '0;
    end else if (start_i) begin
      code_q <= '0;
      mask_q <= {1'b1, {(N-1){1'b0}}};
    end else if (tick_i && (mask_q != '0)) begin
      code_q <= res_o;
      mask_q <= mask_q >> 1;
    end
  end
endmodule

// File: rtl/adc_conv_seq_shift.sv
module adc_conv_seq_shift #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] data_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         empty_o
);
  localparam int CNTW = $clog2(N + 1);
  logic [N-1:0]    sh_q;
  logic [CNTW-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= CNTW'(N);
    end else if (shift_i && (cnt_q != '0)) begin
      sh_q  <= sh_q << 1;
      cnt_q <= cnt_q - 1'b1;
    end
  end
  assign bit_o   = sh_q[N-1];
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_conv_seq_pkg::*;
#(
  parameter int N_BITS = 8,
  parameter int DIV    = 625
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sclk_i,
  input  logic              shdn_ni,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] dac_code_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              track_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int WCW = $clog2(N_BITS + 1);

  logic [2:0] sync_q;
  logic shdn_s, cs_s, sclk_s, cs_d, sclk_d;
  logic cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic div_tick, sar_done, sh_bit, sh_empty, sh_load, sh_shift;
  logic abort_q, err_q, valid_q;
  logic [WCW-1:0] wcnt_q;
  logic [N_BITS-1:0] sar_res;
  seq_st_e st_q, st_d;

  adc_conv_seq_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({shdn_ni, start_i, sclk_i}), .q_o(sync_q)
  );
  assign {shdn_s, cs_s, sclk_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end
  assign cs_rise   = cs_s & ~cs_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  adc_conv_seq_div #(.DIV(DIV)) u_div (
    .clk_i, .rst_ni,
    .clr_i (!(st_q == ST_CONV || st_q == ST_RWAIT)),
    .tick_o(div_tick)
  );

  adc_conv_seq_sar #(.N(N_BITS)) u_sar (
    .clk_i, .rst_ni,
    .start_i(st_q == ST_AZ && cs_fall && shdn_s),
    .abort_i(!shdn_s),
    .tick_i (div_tick && st_q == ST_CONV),
    .cmp_i,
    .dac_o  (dac_code_o),
    .res_o  (sar_res),
    .done_o (sar_done)
  );

  assign sh_load  = (st_q == ST_CONV && sar_done && shdn_s) ||
                    (st_q == ST_RWAIT && st_d == ST_RCLR);
  assign sh_shift = sclk_fall && !cs_s && (st_q == ST_READ || st_q == ST_RCLR);

  adc_conv_seq_shift #(.N(N_BITS)) u_shift (
    .clk_i, .rst_ni,
    .load_i (sh_load),
    .data_i ((st_q == ST_CONV) ? sar_res : '0),
    .shift_i(sh_shift),
    .bit_o  (sh_bit),
    .empty_o(sh_empty)
  );

  always_comb begin
    st_d = st_q;
    if (!shdn_s) st_d = ST_OFF;
    else begin
      unique case (st_q)
        ST_IDLE:  if (cs_rise) st_d = ST_AZ;
        ST_AZ:    if (cs_fall) st_d = ST_CONV;
        ST_CONV:  if (sar_done) st_d = ST_READ;
        ST_READ:  if (sh_empty) st_d = ST_IDLE;
        ST_OFF:   st_d = abort_q ? ST_RWAIT : ST_IDLE;
        ST_RWAIT: if (wcnt_q == WCW'(N_BITS)) st_d = ST_RCLR;
        ST_RCLR:  if (sh_empty) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      abort_q <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      st_q <= st_d;
      // a cut conversion or unfinished recovery needs a full recovery
      if (!shdn_s && (st_q == ST_CONV || st_q == ST_RWAIT || st_q == ST_RCLR))
        abort_q <= 1'b1;
      else if (st_q == ST_RCLR && st_d == ST_IDLE)
        abort_q <= 1'b0;
      if (st_q == ST_IDLE && st_d == ST_AZ)
        err_q <= 1'b0;
      else if ((st_q == ST_CONV && (cs_rise || sclk_rise || sclk_fall)) ||
               (st_q == ST_READ && cs_rise))
        err_q <= 1'b1;
      if (!shdn_s || (st_q == ST_IDLE && cs_rise)) valid_q <= 1'b0;
      else if (st_q == ST_CONV && sar_done)         valid_q <= 1'b1;
      if (st_q != ST_RWAIT) wcnt_q <= '0;
      else if (div_tick)    wcnt_q <= wcnt_q + 1'b1;
    end
  end

  assign sdo_o    = (st_q == ST_READ) ? sh_bit : 1'b0;
  assign sdo_oe_o = (st_q == ST_CONV) || (st_q == ST_READ && !sh_empty);
  assign track_o  = !(st_q == ST_CONV || st_q == ST_OFF);
  assign valid_o  = valid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic shdn_ni,
  input logic sclk_fall_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic track_o,
  input logic valid_o
);
  AST_SHDN_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shdn_ni && $past(!shdn_ni) && $past(!shdn_ni, 2) && $past(!shdn_ni, 3)) |-> !sdo_oe_o); // R9
  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && !track_o) |-> !sdo_o); // R2
  AST_OE_ONLY_ON_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> !track_o); // R2
  AST_VALID_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> track_o); // R4
  AST_SDO_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_oe_o && $past(sdo_oe_o) && track_o && $past(track_o) && !$past(sclk_fall_i))
    |-> $stable(sdo_o)); // R5
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .shdn_ni    (shdn_ni),
  .sclk_fall_i(sclk_fall),
  .sdo_o      (sdo_o),
  .sdo_oe_o   (sdo_oe_o),
  .track_o    (track_o),
  .valid_o    (valid_o)
);

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
  localparam int N = 8;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, sclk = 1'b0, shdn_n = 1'b1;
  logic [N-1:0] code_in = '0, dac;
  logic sdo, oe, track, valid, err, cmp;
  int vectors = 0, fails = 0;

  always #2 clk = ~clk;
  assign cmp = (code_in >= dac);

  adc_conv_seq #(.N_BITS(N), .DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sclk_i(sclk),
    .shdn_ni(shdn_n), .cmp_i(cmp), .dac_code_o(dac), .sdo_o(sdo),
    .sdo_oe_o(oe), .track_o(track), .valid_o(valid), .err_o(err)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic convst(input logic [N-1:0] c);
    code_in = c;
    start = 1'b1;
    wait_clk(5);
    start = 1'b0;
  endtask

  task automatic pulse;
    sclk = 1'b1;
    wait_clk(6);
    sclk = 1'b0;
    wait_clk(6);
  endtask

  // full conversion plus readout of code c, bits checked against c
  task automatic full_cycle(input logic [N-1:0] c);
    convst(c);
    wait_clk(10);
    chk("R2 busy oe", oe, 1);
    chk("R2 busy sdo", sdo, 0);
    chk("R2 busy track", track, 0);
    wait_clk(45);
    chk("R4 msb", sdo, c[N-1]);
    chk("R4 valid", valid, 1);
    chk("R4 track", track, 1);
    chk("R3 result", dac, c);
    for (int b = N - 2; b >= 0; b--) begin
      pulse();
      chk("R5 bit", sdo, c[b]);
      chk("R5 oe", oe, 1);
    end
    pulse();
    chk("R5 tristate", oe, 0);
    pulse();
    chk("R5 extra clk", oe, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(6);
    // R1
    chk("R1 track", track, 1);
    chk("R1 oe", oe, 0);
    chk("R1 valid", valid, 0);
    chk("R1 err", err, 0);
    chk("R1 dac", dac, 0);

    // R3 R4 R5 sweep of every code
    for (int c = 0; c < (1 << N); c++) begin
      full_cycle(N'(c));
      chk("R2 err clean", err, 0);
    end

    // R7 serial clock during conversion
    convst(8'h3c);
    wait_clk(8);
    pulse();
    wait_clk(40);
    chk("R7 err", err, 1);
    for (int i = 0; i < N; i++) pulse();
    chk("R7 readout done", oe, 0);

    // R2 next start clears err
    full_cycle(8'h5a);
    chk("R2 err cleared", err, 0);

    // R8 strobe rise during conversion: no restart
    convst(8'hc3);
    wait_clk(8);
    start = 1'b1;
    wait_clk(6);
    start = 1'b0;
    wait_clk(45);
    chk("R8 err", err, 1);
    chk("R8 valid", valid, 1);
    chk("R8 result", dac, 8'hc3);
    chk("R8 msb", sdo, 1);
    for (int i = 0; i < N; i++) pulse();
    chk("R8 done", oe, 0);

    // R6 strobe during readout
    convst(8'hb2);
    wait_clk(55);
    pulse(); pulse(); pulse();
    chk("R6 bit4", sdo, 1);
    start = 1'b1;
    wait_clk(6);
    chk("R6 err", err, 1);
    pulse();
    chk("R6 no shift", sdo, 1);
    chk("R6 oe", oe, 1);
    start = 1'b0;
    wait_clk(6);
    pulse();
    chk("R6 bit3", sdo, 0);
    pulse();
    chk("R6 bit2", sdo, 0);
    pulse(); pulse();
    chk("R6 bit0", sdo, 0);
    pulse();
    chk("R6 end", oe, 0);

    // R9 shutdown mid conversion
    convst(8'h77);
    wait_clk(12);
    shdn_n = 1'b0;
    wait_clk(4);
    chk("R9 oe", oe, 0);
    chk("R9 track", track, 0);
    chk("R9 valid", valid, 0);
    wait_clk(20);
    chk("R9 held", oe, 0);

    // R10 recovery before next start
    shdn_n = 1'b1;
    wait_clk(5);
    convst(8'h11);
    wait_clk(20);
    chk("R10 ignored oe", oe, 0);
    chk("R10 ignored track", track, 1);
    wait_clk(40);
    convst(8'h11);
    wait_clk(55);
    chk("R10 still ignored", oe, 0);
    for (int i = 0; i < N; i++) pulse();
    full_cycle(8'ha5);

    // R11 idle shutdown needs no recovery
    shdn_n = 1'b0;
    wait_clk(10);
    chk("R11 track off", track, 0);
    shdn_n = 1'b1;
    wait_clk(5);
    chk("R11 track back", track, 1);
    full_cycle(8'h81);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule